// File: doc/BRIEF.md
# Per-Pixel Weighted Video Mixer

This block blends two pixel streams, port A and port B, into one output stream under a weight that can change on every pixel. It is used for dissolves and crossfades. The rate and the start of a transition come only from the weight sequence supplied at the input, and there is no internal ramp. Holding the weight steady leaves a transition partly done for as long as the weight stays unchanged. Both inputs and the output are 24-bit buses. The luma byte sits in bits [23:16]. The two chroma bytes sit in [15:8] and [7:0]. Chroma is offset binary, with 128 meaning no colour.

Three format pairs are supported. In full-chroma in / full-chroma out, every component of a pixel uses that pixel's weight. In half-rate chroma in / half-rate chroma out, each pixel carries luma plus one chroma sample in bits [15:8]. A slot flag marks that sample as the blue-difference sample (flag 0) or the red-difference sample (flag 1). Luma uses every weight. A red-difference sample that directly follows a blue-difference sample reuses the weight held from that blue-difference sample. In half-rate in / full-chroma out, each port's most recent blue- and red-difference samples are held and repeated across the pixel pair. They are blended with the weight of the current pixel.

A small state machine tracks which chroma slot the previous pixel filled. Its states are ST_FULL (the previous pixel was full-chroma or reset), ST_AFTER_CB and ST_AFTER_CR. Every cycle it moves to ST_FULL when the format is full-chroma in. Otherwise it moves to ST_AFTER_CB when the slot flag is 0 and to ST_AFTER_CR when the flag is 1. The weights are clamped to 256 and the mix is `(w*A + (256-w)*B + 128) >> 8` for each byte lane. The result has a fixed two-cycle latency.

Top module: `alpha_mixer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mix_out` is all zeros.
- R2: Inputs sampled at rising edge k appear on `mix_out` after rising edge k+2, with the same latency in every format.
- R3: The luma byte is `(w*A + (256-w)*B + 128) >> 8` of the two ports' bits [23:16] in every format. w is `alpha`, limited to 256, so any value from 256 to 511 selects port A exactly.
- R4: With `fmt` 0 or 3 (full chroma in and out), bytes [15:8] and [7:0] are each mixed with that pixel's limited weight by the R3 formula.
- R5: With `fmt` 1 (half-rate in and out), `mix_out[7:0]` is zero. `mix_out[15:8]` mixes the ports' bits [15:8]. A pixel with `cr_slot`=0 uses its own weight, and a pixel with `cr_slot`=1 whose predecessor was a `fmt` 1 or 2 pixel with `cr_slot`=0 uses that predecessor's weight.
- R6: With `fmt` 1, a pixel with `cr_slot`=1 whose predecessor was not a blue-difference half-rate pixel (reset, full-chroma pixel, or another red-difference pixel) uses its own weight for `mix_out[15:8]`.
- R7: With `fmt` 2 (half-rate in, full out), `mix_out[15:8]` mixes each port's blue-difference sample and `mix_out[7:0]` mixes each port's red-difference sample. The current pixel's bits [15:8] are used for its own slot, and the last held sample of the other slot is used for the other lane. Both lanes use the current pixel's limited weight.
- R8: After reset the held chroma samples of both ports are 128, so a first `fmt` 2 pixel mixes 128 with 128 in its other-slot lane and yields 128.
- R9: Mixing two zero-chroma (128) samples gives 128 for any weight.
- R10: Weight, pixels and format held constant for consecutive full-chroma cycles give a constant `mix_out` (a transition held partway).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| alpha | input | 9 | Per-pixel weight of port A, 256 = all A |
| fmt | input | 2 | 0 full/full, 1 half/half, 2 half/full, 3 as 0 |
| cr_slot | input | 1 | Half-rate chroma slot: 0 blue-difference, 1 red-difference |
| pix_a | input | 24 | Port A pixel: [23:16] luma, [15:8] and [7:0] chroma |
| pix_b | input | 24 | Port B pixel, same layout |
| mix_out | output | 24 | Blended pixel, two cycles after its inputs |

## Verification
The bench builds the mixer with its default 8-bit components and 9-bit weight. This covers the full weight range, including the unity point 256 and the out-of-range values 257 to 511 that must clamp. With 8-bit lanes the rounding term and every byte value can be driven exhaustively at the edges (0, 1, 255) and at random elsewhere. The same width lets the held-weight and held-chroma paths be entered from reset, from a full-chroma pixel and from repeated red-difference pixels.

// File: rtl/alpha_mix_pkg.sv
`timescale 1ns/1ps
package alpha_mix_pkg;

    // Input/output format pairing selected by the fmt port
    typedef enum logic [1:0] {
        FMT_444_444 = 2'd0,
        FMT_422_422 = 2'd1,
        FMT_422_444 = 2'd2,
        FMT_SPARE   = 2'd3
    } mix_fmt_e;

    // Which chroma slot the previous pixel filled
    typedef enum logic [1:0] {
        ST_FULL     = 2'd0,
        ST_AFTER_CB = 2'd1,
        ST_AFTER_CR = 2'd2
    } chroma_st_e;

    // Byte lanes per pixel: index 2 luma, 1 first chroma, 0 second chroma
    localparam int LANES = 3;

endpackage

// File: rtl/amx_lane.sv
`timescale 1ns/1ps
module amx_lane #(
    parameter int CW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] weight,
    input  logic [CW-1:0] op_a,
    input  logic [CW-1:0] op_b,
    output logic [CW-1:0] mixed
);
    localparam int FRAC = AW - 1;
    localparam int PW   = CW + AW + 1;
    localparam logic [AW-1:0] UNITY = AW'(1) << FRAC;
    localparam logic [PW-1:0] HALF  = PW'(1) << (FRAC - 1);

    logic [AW-1:0] w_q;
    logic [CW-1:0] a_q;
    logic [CW-1:0] b_q;
    logic [PW-1:0] term_a;
    logic [PW-1:0] term_b;
    logic [PW-1:0] acc;

    // Stage 1: capture operands and weight
    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            w_q <= weight;
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    // Weighted sum with round-half-up
    always_comb begin
        term_a = PW'(w_q) * PW'(a_q);
        term_b = PW'(UNITY - w_q) * PW'(b_q);
        acc    = term_a + term_b + HALF;
    end

    // Stage 2: registered result
    always_ff @(posedge clk) begin
        if (rst) begin
            mixed <= '0;
        end else begin
            mixed <= acc[FRAC +: CW];
        end
    end

endmodule

// File: rtl/amx_chroma_ctrl.sv
`timescale 1ns/1ps
module amx_chroma_ctrl
    import alpha_mix_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  mix_fmt_e      fmt,
    input  logic          cr_slot,
    input  logic [AW-1:0] w_now,
    input  logic [CW-1:0] a_c1,
    input  logic [CW-1:0] b_c1,
    input  logic [CW-1:0] a_c0,
    input  logic [CW-1:0] b_c0,
    output logic [AW-1:0] w1,
    output logic [AW-1:0] w0,
    output logic [CW-1:0] op_a1,
    output logic [CW-1:0] op_b1,
    output logic [CW-1:0] op_a0,
    output logic [CW-1:0] op_b0
);
    localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);

    chroma_st_e    state_q;
    chroma_st_e    state_d;
    logic          half_in;
    logic [AW-1:0] w_hold;
    logic [CW-1:0] a_cb_h;
    logic [CW-1:0] b_cb_h;
    logic [CW-1:0] a_cr_h;
    logic [CW-1:0] b_cr_h;

    assign half_in = (fmt == FMT_422_422) || (fmt == FMT_422_444);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (fmt)
            FMT_422_422, FMT_422_444: state_d = cr_slot ? ST_AFTER_CR : ST_AFTER_CB;
            default:                  state_d = ST_FULL;
        endcase
    end

    // Held weight and chroma samples from half-rate pixels
    always_ff @(posedge clk) begin
        if (rst) begin
            w_hold <= '0;
            a_cb_h <= MID;
            b_cb_h <= MID;
            a_cr_h <= MID;
            b_cr_h <= MID;
        end else if (half_in) begin
            if (!cr_slot) begin
                w_hold <= w_now;
                a_cb_h <= a_c1;
                b_cb_h <= b_c1;
            end else begin
                a_cr_h <= a_c1;
                b_cr_h <= b_c1;
            end
        end
    end

    // Lane weights and operands
    always_comb begin
        w1    = w_now;
        w0    = w_now;
        op_a1 = a_c1;
        op_b1 = b_c1;
        op_a0 = a_c0;
        op_b0 = b_c0;
        unique case (fmt)
            FMT_422_422: begin
                op_a0 = '0;
                op_b0 = '0;
                w0    = '0;
                if (cr_slot) begin
                    unique case (state_q)
                        ST_AFTER_CB: w1 = w_hold;
                        ST_AFTER_CR: w1 = w_now;
                        default:     w1 = w_now;
                    endcase
                end
            end
            FMT_422_444: begin
                op_a1 = cr_slot ? a_cb_h : a_c1;
                op_b1 = cr_slot ? b_cb_h : b_c1;
                op_a0 = cr_slot ? a_c1 : a_cr_h;
                op_b0 = cr_slot ? b_c1 : b_cr_h;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/alpha_mixer.sv
`timescale 1ns/1ps
module alpha_mixer
    import alpha_mix_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       alpha,
    input  logic [1:0]          fmt,
    input  logic                cr_slot,
    input  logic [LANES*CW-1:0] pix_a,
    input  logic [LANES*CW-1:0] pix_b,
    output logic [LANES*CW-1:0] mix_out
);
    localparam logic [AW-1:0] UNITY = AW'(1) << (AW - 1);

    mix_fmt_e      fmt_e;
    logic [AW-1:0] w_eff;
    logic [AW-1:0] lane_w [LANES];
    logic [CW-1:0] lane_a [LANES];
    logic [CW-1:0] lane_b [LANES];
    logic [CW-1:0] lane_y [LANES];

    assign fmt_e = mix_fmt_e'(fmt);
    assign w_eff = (alpha > UNITY) ? UNITY : alpha;

    // Luma always uses the full-rate weight
    assign lane_w[2] = w_eff;
    assign lane_a[2] = pix_a[2*CW +: CW];
    assign lane_b[2] = pix_b[2*CW +: CW];

    amx_chroma_ctrl #(.CW(CW), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt_e),
        .cr_slot (cr_slot),
        .w_now   (w_eff),
        .a_c1    (pix_a[CW +: CW]),
        .b_c1    (pix_b[CW +: CW]),
        .a_c0    (pix_a[0 +: CW]),
        .b_c0    (pix_b[0 +: CW]),
        .w1      (lane_w[1]),
        .w0      (lane_w[0]),
        .op_a1   (lane_a[1]),
        .op_b1   (lane_b[1]),
        .op_a0   (lane_a[0]),
        .op_b0   (lane_b[0])
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        amx_lane #(.CW(CW), .AW(AW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .weight (lane_w[i]),
            .op_a   (lane_a[i]),
            .op_b   (lane_b[i]),
            .mixed  (lane_y[i])
        );
        assign mix_out[i*CW +: CW] = lane_y[i];
    end

endmodule

// File: rtl/amx_checker.sv
`timescale 1ns/1ps
module amx_checker #(
    parameter int CW = 8,
    parameter int AW = 9
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   alpha,
    input logic [1:0]      fmt,
    input logic            cr_slot,
    input logic [3*CW-1:0] pix_a,
    input logic [3*CW-1:0] pix_b,
    input logic [3*CW-1:0] mix_out
);
    localparam logic [AW-1:0] UNITY = AW'(1) << (AW - 1);
    localparam logic [CW-1:0] MID   = CW'(1) << (CW - 1);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    assert_unity_selects_a_R3: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(alpha, 2) >= UNITY)
        |-> mix_out[3*CW-1 -: CW] == $past(pix_a[3*CW-1 -: CW], 2));

    assert_zero_weight_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(alpha, 2) == '0)
        |-> mix_out[3*CW-1 -: CW] == $past(pix_b[3*CW-1 -: CW], 2));

    assert_full_chroma_unity_R4: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(alpha, 2) >= UNITY && ($past(fmt, 2) == 2'd0 || $past(fmt, 2) == 2'd3))
        |-> mix_out == $past(pix_a, 2));

    assert_half_low_lane_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(fmt, 2) == 2'd1)
        |-> mix_out[CW-1:0] == '0);

    assert_zero_chroma_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(fmt, 2) == 2'd0
         && $past(pix_a[CW +: CW], 2) == MID && $past(pix_b[CW +: CW], 2) == MID)
        |-> mix_out[CW +: CW] == MID);

    assert_held_transition_R10: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(fmt, 2) == 2'd0 && $past(fmt, 3) == 2'd0
         && $past(alpha, 2) == $past(alpha, 3)
         && $past(pix_a, 2) == $past(pix_a, 3) && $past(pix_b, 2) == $past(pix_b, 3))
        |-> mix_out == $past(mix_out));

endmodule

bind alpha_mixer amx_checker #(.CW(CW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .alpha   (alpha),
    .fmt     (fmt),
    .cr_slot (cr_slot),
    .pix_a   (pix_a),
    .pix_b   (pix_b),
    .mix_out (mix_out)
);

// File: tb/sim_alpha_mixer.sv
`timescale 1ns/1ps
module sim_alpha_mixer;
    localparam int CW = 8;
    localparam int AW = 9;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  alpha;
    logic [1:0]  fmt;
    logic        cr_slot;
    logic [23:0] pix_a;
    logic [23:0] pix_b;
    logic [23:0] mix_out;

    always #10 clk = ~clk;

    alpha_mixer #(.CW(CW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .alpha(alpha), .fmt(fmt), .cr_slot(cr_slot),
        .pix_a(pix_a), .pix_b(pix_b), .mix_out(mix_out)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    // Behavioural model state
    int m_prev;     // 0 full/reset, 1 blue-difference, 2 red-difference
    int m_hold_w;
    int m_acb, m_bcb, m_acr, m_bcr;

    function automatic int mixv(int w, int x, int y);
        return (w * x + (256 - w) * y + 128) / 256;
    endfunction

    task automatic model_reset();
        m_prev = 0; m_hold_w = 0;
        m_acb = 128; m_bcb = 128; m_acr = 128; m_bcr = 128;
    endtask

    task automatic apply(input logic [1:0] f, input logic c, input logic [8:0] a,
                         input logic [23:0] pa, input logic [23:0] pb, input string tag);
        int w, e2, e1, e0, w1;
        alpha = a; fmt = f; cr_slot = c; pix_a = pa; pix_b = pb;
        w  = (int'(a) > 256) ? 256 : int'(a);
        e2 = mixv(w, pa[23:16], pb[23:16]);
        if (f == 2'd1) begin
            w1 = (c && m_prev == 1) ? m_hold_w : w;
            e1 = mixv(w1, pa[15:8], pb[15:8]);
            e0 = 0;
        end else if (f == 2'd2) begin
            e1 = c ? mixv(w, m_acb, m_bcb) : mixv(w, pa[15:8], pb[15:8]);
            e0 = c ? mixv(w, pa[15:8], pb[15:8]) : mixv(w, m_acr, m_bcr);
        end else begin
            e1 = mixv(w, pa[15:8], pb[15:8]);
            e0 = mixv(w, pa[7:0], pb[7:0]);
        end
        if (f == 2'd1 || f == 2'd2) begin
            m_prev = c ? 2 : 1;
            if (!c) begin
                m_hold_w = w; m_acb = pa[15:8]; m_bcb = pb[15:8];
            end else begin
                m_acr = pa[15:8]; m_bcr = pb[15:8];
            end
        end else begin
            m_prev = 0;
        end
        exp_q.push_back({e2[7:0], e1[7:0], e0[7:0]});
        tag_q.push_back(tag);
    endtask

    task automatic compare();
        logic [23:0] e;
        string t;
        if (exp_q.size() == 2) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            // two-cycle latency R2 applies to every compare
            if (mix_out !== e) begin
                miscompares++;
                $display("FAIL R2 %s: got %h expected %h", t, mix_out, e);
            end
        end
    endtask

    task automatic tick(input logic [1:0] f, input logic c, input logic [8:0] a,
                        input logic [23:0] pa, input logic [23:0] pb, input string tag);
        @(negedge clk);
        compare();
        apply(f, c, a, pa, pb, tag);
    endtask

    function automatic logic [23:0] rpix();
        return 24'($urandom);
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        logic [23:0] ca, cb;
        logic [8:0]  ka;
        logic [1:0]  fr;
        rst = 1'b1; alpha = '0; fmt = '0; cr_slot = 1'b0; pix_a = '0; pix_b = '0;
        model_reset();
        pix_a = 24'hFFFFFF; pix_b = 24'hFFFFFF; alpha = 9'd100;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vectors++;
            if (mix_out !== 24'h0) begin
                miscompares++;
                $display("FAIL R1 reset: got %h expected %h", mix_out, 24'h0);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        exp_q.push_back(24'h0);          // R1: first cycle after reset
        tag_q.push_back("R1 after reset");
        // R8: first half-in/full-out pixel uses 128 for the held red lane
        apply(2'd2, 1'b0, 9'd77, rpix(), rpix(), "R8 held chroma at reset");
        tick(2'd2, 1'b1, 9'd190, rpix(), rpix(), "R7 pair completes");

        // R3 clamp and boundary weights
        foreach (ka_list[i]) tick(2'd0, 1'b0, ka_list[i], rpix(), rpix(), "R3 weight boundary");
        tick(2'd0, 1'b0, 9'd128, 24'h00FF00, 24'hFF00FF, "R3 rounding");

        // R4 full chroma random
        for (int i = 0; i < 400; i++)
            tick(($urandom % 2) ? 2'd0 : 2'd3, 1'($urandom), 9'($urandom), rpix(), rpix(), "R4 full chroma");

        // R9 zero chroma stays 128
        for (int i = 0; i < 20; i++)
            tick(2'd0, 1'b0, 9'($urandom), {8'($urandom), 16'h8080}, {8'($urandom), 16'h8080}, "R9 zero chroma");

        // R5 half in / half out alternating slots
        for (int i = 0; i < 400; i++)
            tick(2'd1, 1'(i % 2), 9'($urandom), rpix(), rpix(), "R5 held blue weight");

        // R6 red-difference without a preceding blue-difference sample
        for (int i = 0; i < 50; i++) begin
            tick(2'd0, 1'b0, 9'($urandom), rpix(), rpix(), "R4 full chroma");
            tick(2'd1, 1'b1, 9'($urandom), rpix(), rpix(), "R6 orphan after full");
            tick(2'd1, 1'b1, 9'($urandom), rpix(), rpix(), "R6 orphan after red");
            tick(2'd1, 1'b0, 9'($urandom), rpix(), rpix(), "R5 blue sample");
            tick(2'd1, 1'b1, 9'($urandom), rpix(), rpix(), "R5 red reuses blue weight");
        end

        // R7 half in / full out
        for (int i = 0; i < 400; i++)
            tick(2'd2, 1'(i % 2), 9'($urandom), rpix(), rpix(), "R7 repeated chroma");

        // Mixed formats and slots
        for (int i = 0; i < 400; i++) begin
            fr = 2'($urandom);
            tick(fr, 1'($urandom), 9'($urandom), rpix(), rpix(), "R3 mixed formats");
        end

        // R10 transition held partway
        for (int m = 0; m < 3; m++) begin
            ca = rpix(); cb = rpix(); ka = 9'(40 + 60 * m);
            for (int i = 0; i < 20; i++)
                tick(2'(m), 1'b0, ka, ca, cb, "R10 held weight");
        end

        tick(2'd0, 1'b0, 9'd0, 24'h0, 24'h0, "R3 drain");
        tick(2'd0, 1'b0, 9'd0, 24'h0, 24'h0, "R3 drain");
        @(negedge clk);
        compare();
        finished = 1;
        report();
        $finish;
    end

    logic [8:0] ka_list [8] = '{9'd0, 9'd1, 9'd127, 9'd255, 9'd256, 9'd257, 9'd400, 9'd511};

endmodule